// File: doc/BRIEF.md
# Full-Duplex Serial Port with Two-Range Bit-Rate Divider

This block is an asynchronous serial transmitter and receiver that run at the same time and independently of each other. It is clocked at six ticks per instruction cycle. An 8-bit divisor `n` and a speed bit set the bit period. With the speed bit set, one bit lasts `(n+1)*8` ticks. With it clear, one bit lasts `(n+1)*32` ticks. A divisor of zero behaves like one.

A frame is one low start bit, then 7, 8 or 9 data bits sent least significant bit first, then one high stop bit. There is no parity bit. Software loads a word and pulses a start strobe. It then watches a busy flag. Each direction reports the end of a frame with a one-cycle completion pulse, which serves as that direction's interrupt request. A frame whose stop bit reads low is still delivered, and the framing-error flag is raised with it.

Top module: `uart_dual_baud`

## Requirements
- R1: With `cfg_fast`=1, every bit on `txd` lasts `(n+1)*8` clock cycles, where `n` is `cfg_div`.
- R2: With `cfg_fast`=0, every bit on `txd` lasts `(n+1)*32` clock cycles.
- R3: A `cfg_div` value of 0 gives the same bit period as a value of 1.
- R4: `cfg_len` selects the data length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, and 2'b10 or 2'b11 gives 9 bits. A frame on `txd` is a low start bit, then data bits `tx_data[0]` upward, then one high stop bit. `txd` is high whenever `tx_busy` is low.
- R5: `tx_busy` rises in the cycle after `tx_start` is accepted. It stays high for the whole frame. It falls in the same cycle as a single-cycle `tx_done` pulse.
- R6: A `tx_start` pulse while `tx_busy` is high is ignored. The current frame's bits are unchanged, and no further frame follows it.
- R7: Divisor, speed and length are captured when a frame begins. Changing them during a frame has no effect on that frame, in either direction.
- R8: The receiver starts a frame on a falling edge of the synchronized `rxd`. It re-reads the line half a bit later, and a low pulse shorter than half a bit produces no frame.
- R9: Received data bits are sampled at their midpoints and assembled least significant bit first. `rx_data` is right-aligned with the unused upper bits zero, and it updates together with a single-cycle `rx_done` pulse.
- R10: A stop bit that samples low still stores the data and sets `rx_ferr`. `rx_ferr` and `rx_data` change only with `rx_done`, so the next correctly framed word clears `rx_ferr`.
- R11: Transmit and receive run concurrently. When `tx_done` and `rx_done` fall in the same cycle, both are reported and both words are correct.
- R12: After reset, `txd` is 1, `tx_busy`, `tx_done`, `rx_done` and `rx_ferr` are 0, and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, six ticks per instruction cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 8 | Bit-rate divisor n |
| cfg_fast | input | 1 | 1: period (n+1)*8 ticks, 0: (n+1)*32 ticks |
| cfg_len | input | 2 | Data length code (7, 8 or 9 bits) |
| tx_data | input | 9 | Word to transmit, right-aligned |
| tx_start | input | 1 | Strobe that starts a transmit frame |
| tx_busy | output | 1 | Transmit frame in progress |
| tx_done | output | 1 | One-cycle pulse at the end of the stop bit |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line, asynchronous |
| rx_data | output | 9 | Last received word, right-aligned |
| rx_done | output | 1 | One-cycle pulse when a received word is stored |
| rx_ferr | output | 1 | Stop bit of the last received word was low |

## Verification
The transmit completion and the receive completion can land on the same clock edge. The two directions share no state, so each must still report its own completion in that cycle. To provoke this, the bench starts a transmit frame and an independent receive frame with a start offset swept one cycle at a time across a full bit period. At some offset the two completion pulses must coincide. In every sweep step, the bench counts both pulses, checks the received word, and requires that at least one step showed both pulses on the same edge.

// File: rtl/uart_dual_pkg.sv
// Shared types and helpers for the dual-range serial port.
// Assumes a fixed maximum word of nine data bits.
package uart_dual_pkg;

    localparam int DATA_W = 9;

    // Receiver sequencing states.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // Data-bit count for a length code: 00 -> 7, 01 -> 8, otherwise 9.
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd7;
            2'b01:   return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/uart_baud_period.sv
// Turns divisor and speed selection into a bit period in clock ticks.
// Assumes the clock runs at six ticks per instruction cycle, so the
// fine range is (n+1)<<FAST_SHIFT and the coarse range (n+1)<<SLOW_SHIFT.
module uart_baud_period #(
    parameter int DIV_W      = 8,
    parameter int FAST_SHIFT = 3,
    parameter int SLOW_SHIFT = 5,
    parameter int PER_W      = DIV_W + 1 + SLOW_SHIFT
) (
    input  logic [DIV_W-1:0] div,
    input  logic             fast,
    output logic [PER_W-1:0] period
);
    logic [DIV_W-1:0] div_eff;
    logic [PER_W-1:0] mult;

    // Clamp a zero divisor to one, then scale by the selected range.
    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        mult    = PER_W'(div_eff) + PER_W'(1);
        period  = fast ? (mult << FAST_SHIFT) : (mult << SLOW_SHIFT);
    end
endmodule

// File: rtl/uart_tx_engine.sv
// Transmit side: serializes one start bit, the data bits LSB first and
// one stop bit. Period and length are latched when a frame is accepted.
// Assumes period >= 2.
module uart_tx_engine
    import uart_dual_pkg::*;
#(
    parameter int PER_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period,
    input  logic [1:0]        len_code,
    input  logic [DATA_W-1:0] data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int SYM_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame_n;
    logic [FRAME_W-1:0] shreg;
    logic [SYM_W-1:0]   sym;
    logic [SYM_W-1:0]   last_sym;
    logic [PER_W-1:0]   per_q;
    logic [PER_W-1:0]   cnt;
    logic [3:0]         nbits;

    // Build the full frame: start low, data, then ones for stop and padding.
    always_comb begin
        nbits   = word_bits(len_code);
        frame_n = '1;
        frame_n[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nbits)) frame_n[i+1] = data[i];
        end
    end

    // Frame sequencer: accept, time each symbol, shift out, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            txd      <= 1'b1;
            shreg    <= '1;
            sym      <= '0;
            last_sym <= '0;
            per_q    <= '0;
            cnt      <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    shreg    <= frame_n;
                    txd      <= frame_n[0];
                    sym      <= '0;
                    last_sym <= SYM_W'(nbits) + SYM_W'(1);
                    per_q    <= period;
                    cnt      <= '0;
                end
            end else if (cnt == per_q - PER_W'(1)) begin
                cnt <= '0;
                if (sym == last_sym) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    txd  <= 1'b1;
                end else begin
                    sym   <= sym + SYM_W'(1);
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    txd   <= shreg[1];
                end
            end else begin
                cnt <= cnt + PER_W'(1);
            end
        end
    end
endmodule

// File: rtl/uart_rx_engine.sv
// Receive side: synchronizes rxd, detects a falling edge, confirms the
// start bit half a period later, then samples each bit at its midpoint.
// A low stop bit still stores the word and flags a framing error.
// Assumes period >= 4.
module uart_rx_engine
    import uart_dual_pkg::*;
#(
    parameter int PER_W       = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period,
    input  logic [1:0]        len_code,
    input  logic              rxd,
    output logic [DATA_W-1:0] data,
    output logic              done,
    output logic              ferr
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic [SYNC_STAGES:0] sync;
    logic                 line;
    logic                 line_prev;
    rx_state_t            state;
    logic [PER_W-1:0]     per_q;
    logic [PER_W-1:0]     cnt;
    logic [3:0]           len_q;
    logic [IDX_W-1:0]     idx;
    logic [DATA_W-1:0]    shr;
    logic [DATA_W-1:0]    aligned;

    // Metastability chain plus one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= '1;
        else        sync <= {sync[SYNC_STAGES-1:0], rxd};
    end

    assign line      = sync[SYNC_STAGES-1];
    assign line_prev = sync[SYNC_STAGES];

    // Right-align the bits shifted in from the top.
    always_comb aligned = shr >> (DATA_W - int'(len_q));

    // Receive sequencer: edge, start check, data bits, stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            per_q <= '0;
            cnt   <= '0;
            len_q <= 4'd8;
            idx   <= '0;
            shr   <= '0;
            data  <= '0;
            done  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (line_prev && !line) begin
                        per_q <= period;
                        len_q <= word_bits(len_code);
                        cnt   <= '0;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (cnt == (per_q >> 1) - PER_W'(1)) begin
                        cnt <= '0;
                        idx <= '0;
                        state <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + PER_W'(1);
                    end
                end
                RX_DATA: begin
                    if (cnt == per_q - PER_W'(1)) begin
                        cnt <= '0;
                        shr <= {line, shr[DATA_W-1:1]};
                        if (idx == IDX_W'(len_q) - IDX_W'(1)) state <= RX_STOP;
                        else idx <= idx + IDX_W'(1);
                    end else begin
                        cnt <= cnt + PER_W'(1);
                    end
                end
                default: begin
                    if (cnt == per_q - PER_W'(1)) begin
                        cnt   <= '0;
                        data  <= aligned;
                        ferr  <= !line;
                        done  <= 1'b1;
                        state <= RX_IDLE;
                    end else begin
                        cnt <= cnt + PER_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_dual_baud.sv
// Top of the full-duplex serial port. One period calculator feeds two
// independent engines; each engine latches its own copy per frame.
// Assumes clk is six ticks per instruction cycle.
module uart_dual_baud
    import uart_dual_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int FAST_SHIFT  = 3,
    parameter int SLOW_SHIFT  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_fast,
    input  logic [1:0]        cfg_len,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done,
    output logic              rx_ferr
);
    localparam int PER_W = DIV_W + 1 + SLOW_SHIFT;

    logic [PER_W-1:0] period;

    uart_baud_period #(
        .DIV_W(DIV_W), .FAST_SHIFT(FAST_SHIFT),
        .SLOW_SHIFT(SLOW_SHIFT), .PER_W(PER_W)
    ) i_period (
        .div(cfg_div), .fast(cfg_fast), .period(period)
    );

    uart_tx_engine #(.PER_W(PER_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .period(period), .len_code(cfg_len),
        .data(tx_data), .start(tx_start), .busy(tx_busy),
        .done(tx_done), .txd(txd)
    );

    uart_rx_engine #(.PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)) i_rx (
        .clk(clk), .rst_n(rst_n), .period(period), .len_code(cfg_len),
        .rxd(rxd), .data(rx_data), .done(rx_done), .ferr(rx_ferr)
    );
endmodule

// File: rtl/uart_dual_baud_chk.sv
// Protocol checker for the serial port, attached by bind.
// Observes top-level ports only.
module uart_dual_baud_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_busy,
    input logic       tx_done,
    input logic       txd,
    input logic [8:0] rx_data,
    input logic       rx_done,
    input logic       rx_ferr
);
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> tx_done);

    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !tx_busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    a_r10_ferr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_ferr) |-> rx_done);

    a_r10_data_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_done);
endmodule

bind uart_dual_baud uart_dual_baud_chk i_chk (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .tx_done(tx_done),
    .txd(txd), .rx_data(rx_data), .rx_done(rx_done), .rx_ferr(rx_ferr)
);

// File: tb/test_uart_dual_baud.sv
`timescale 1ns/1ps
module test_uart_dual_baud;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_div = 8'd1;
    logic       cfg_fast = 1'b1;
    logic [1:0] cfg_len = 2'b01;
    logic [8:0] tx_data = '0;
    logic       tx_start = 1'b0;
    logic       tx_busy, tx_done, txd, rxd, rx_done, rx_ferr;
    logic [8:0] rx_data;
    logic       loop = 1'b0;
    logic       rxd_drv = 1'b1;

    int nchk = 0, nerr = 0;
    int rx_cnt = 0, tx_cnt = 0, both_cnt = 0;
    logic [8:0] got_data = '0;
    logic       got_ferr = 1'b0;

    always #4 clk = ~clk;

    assign rxd = loop ? txd : rxd_drv;

    uart_dual_baud i_uart_dual_baud (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fast(cfg_fast),
        .cfg_len(cfg_len), .tx_data(tx_data), .tx_start(tx_start),
        .tx_busy(tx_busy), .tx_done(tx_done), .txd(txd), .rxd(rxd),
        .rx_data(rx_data), .rx_done(rx_done), .rx_ferr(rx_ferr)
    );

    // Completion monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_done) begin
                rx_cnt++;
                got_data = rx_data;
                got_ferr = rx_ferr;
            end
            if (tx_done) tx_cnt++;
            if (rx_done && tx_done) both_cnt++;
        end
    end

    // Stimulus vectors: {len code, fast, divisor, data}.
    localparam int NVEC = 7;
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {2'b01, 1'b1, 8'd1,   9'h0A5},
        {2'b00, 1'b1, 8'd2,   9'h15A},
        {2'b10, 1'b1, 8'd3,   9'h1C3},
        {2'b01, 1'b0, 8'd1,   9'h03C},
        {2'b11, 1'b0, 8'd0,   9'h155},
        {2'b00, 1'b0, 8'd2,   9'h033},
        {2'b01, 1'b1, 8'd255, 9'h081}
    };

    function automatic int bits_of(input logic [1:0] c);
        return (c == 2'b00) ? 7 : (c == 2'b01) ? 8 : 9;
    endfunction

    function automatic int per_of(input logic [7:0] d, input logic f);
        int n;
        n = (d == 0) ? 1 : int'(d);
        return (n + 1) * (f ? 8 : 32);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Start a frame and check every bit at its midpoint plus busy/done.
    task automatic tx_frame_check(input logic [8:0] d, input int len,
                                  input int p, input string tag);
        int expb;
        @(negedge clk);
        tx_data  = d;
        tx_start = 1'b1;
        @(posedge clk);
        #2 tx_start = 1'b0;
        for (int s = 0; s < len + 2; s++) begin
            repeat (p / 2) @(posedge clk);
            #2;
            expb = (s == 0) ? 0 : (s <= len) ? int'(d[s-1]) : 1;
            chk({tag, " txd bit"}, int'(txd), expb);
            chk({tag, " busy mid-frame"}, int'(tx_busy), 1);
            repeat (p - p / 2) @(posedge clk);
        end
        #2;
        chk({tag, " R5 busy falls at end"}, int'(tx_busy), 0);
        chk({tag, " R5 done pulse"}, int'(tx_done), 1);
        @(posedge clk);
        #2 chk({tag, " R5 done single"}, int'(tx_done), 0);
    endtask

    // Drive one frame onto rxd from the bench.
    task automatic send_rx(input logic [8:0] d, input int len, input int p,
                           input logic stopv);
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            rxd_drv = d[i];
            repeat (p) @(negedge clk);
        end
        rxd_drv = stopv;
        repeat (p) @(negedge clk);
        rxd_drv = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int c0, p;
        logic [8:0] exp_d;
        logic [19:0] v;
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #1;
        // R12: reset state
        chk("R12 txd", int'(txd), 1);
        chk("R12 tx_busy", int'(tx_busy), 0);
        chk("R12 tx_done", int'(tx_done), 0);
        chk("R12 rx_done", int'(rx_done), 0);
        chk("R12 rx_ferr", int'(rx_ferr), 0);
        chk("R12 rx_data", int'(rx_data), 0);

        // R1 R2 R3 R4 R9: vector table, loopback through the receiver
        loop = 1'b1;
        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            cfg_len  = v[19:18];
            cfg_fast = v[17];
            cfg_div  = v[16:9];
            p = per_of(v[16:9], v[17]);
            c0 = rx_cnt;
            tx_frame_check(v[8:0], bits_of(v[19:18]), p, "R1 R2 R3 R4 vector");
            repeat (3) @(posedge clk);
            #2;
            exp_d = v[8:0] & 9'((1 << bits_of(v[19:18])) - 1);
            chk("R9 one rx word per frame", rx_cnt, c0 + 1);
            chk("R9 rx word", int'(got_data), int'(exp_d));
            chk("R10 no ferr on good frame", int'(got_ferr), 0);
        end

        // R7: change configuration mid-frame, both directions latched
        cfg_len = 2'b01; cfg_fast = 1'b1; cfg_div = 8'd1;
        c0 = rx_cnt;
        fork
            tx_frame_check(9'h096, 8, 16, "R7 cfg change");
            begin
                repeat (20) @(posedge clk);
                #3 cfg_fast = 1'b0; cfg_div = 8'd9; cfg_len = 2'b00;
            end
        join
        repeat (3) @(posedge clk);
        #2;
        chk("R7 rx count", rx_cnt, c0 + 1);
        chk("R7 rx word", int'(got_data), 9'h096);
        cfg_len = 2'b01; cfg_fast = 1'b1; cfg_div = 8'd1;

        // R6: strobe while busy is ignored
        fork
            tx_frame_check(9'h0E1, 8, 16, "R6 strobe while busy");
            begin
                repeat (40) @(posedge clk);
                #3 tx_data = 9'h01E; tx_start = 1'b1;
                @(posedge clk);
                #3 tx_start = 1'b0;
            end
        join
        repeat (40) @(posedge clk);
        #2 chk("R6 no extra frame", int'(tx_busy), 0);
        chk("R6 line idle", int'(txd), 1);

        // R8: short low glitch produces no word, then a good frame is taken
        loop = 1'b0;
        c0 = rx_cnt;
        @(negedge clk); rxd_drv = 1'b0;
        repeat (3) @(negedge clk); rxd_drv = 1'b1;
        repeat (40) @(negedge clk);
        chk("R8 glitch ignored", rx_cnt, c0);
        send_rx(9'h04B, 8, 16, 1'b1);
        repeat (4) @(negedge clk);
        chk("R8 recovery count", rx_cnt, c0 + 1);
        chk("R8 recovery word", int'(got_data), 9'h04B);

        // R10: low stop bit stores data and flags, next good frame clears
        send_rx(9'h0C7, 8, 16, 1'b0);
        repeat (4) @(negedge clk);
        chk("R10 data kept on ferr", int'(rx_data), 9'h0C7);
        chk("R10 ferr set", int'(rx_ferr), 1);
        repeat (20) @(negedge clk);
        chk("R10 ferr held", int'(rx_ferr), 1);
        send_rx(9'h012, 8, 16, 1'b1);
        repeat (4) @(negedge clk);
        chk("R10 ferr cleared", int'(rx_ferr), 0);
        chk("R10 next word", int'(rx_data), 9'h012);

        // R11: concurrent frames with swept offset
        for (int d = 0; d < 16; d++) begin
            int t0, r0;
            t0 = tx_cnt; r0 = rx_cnt;
            fork
                begin
                    @(negedge clk);
                    tx_data = 9'h0A0 + 9'(d);
                    tx_start = 1'b1;
                    @(negedge clk);
                    tx_start = 1'b0;
                end
                begin
                    repeat (d) @(negedge clk);
                    send_rx(9'h050 + 9'(d), 8, 16, 1'b1);
                end
            join
            while (tx_busy) @(negedge clk);
            repeat (4) @(negedge clk);
            chk("R11 tx completion", tx_cnt, t0 + 1);
            chk("R11 rx completion", rx_cnt, r0 + 1);
            chk("R11 rx word", int'(got_data), int'(9'h050 + 9'(d)));
        end
        nchk++;
        if (both_cnt < 1) begin
            nerr++;
            $display("FAIL R11 coincident completions actual=%0d expected>=1", both_cnt);
        end

        finish_run();
    end
endmodule